// File: doc/BRIEF.md
# Serial DMA Host Register Front End

This block is the host-facing register interface of a four-channel serial DMA cell. The four channels are receive A, transmit A, receive B and transmit B. A host reaches it over a plain 8-bit bus with chip select and separate read and write strobes. There are no address pins. Instead, a 5-bit internal pointer chooses the register that each access reaches. A write at the base location does two things: it loads the pointer and it issues a channel command. The access after that reaches the selected register, and then the pointer falls back to the base location by itself.

Reading the base location returns latched terminal-count and abort events from the transfer engines. That status clears when it is read. A second register holds the interrupt controls. From those controls and the latched status, the block drives an interrupt request and the enable-out signal of an interrupt daisy chain. The transfer engines lie outside the block. They are seen only as one-cycle event pulses, and the block sends them a channel-enable level for each channel.

The bus inputs are sampled on the block clock. A strobe counts as one access for as long as it is held.

Top module: `sdma_regfront`

## Requirements
- R1: After reset, the pointer selects the base location (0), all status bits are 0, the interrupt control register is 0, every channel enable is 0 and `irq` is 0.
- R2: A write while the pointer is 0 loads `wdata[4:0]` into the pointer. The next access, read or write, reaches the selected register. After that access the pointer is 0 again.
- R3: A read at the base location returns status on `rdata`. Bits 7..4 are terminal count and bits 3..0 are abort. Within each group the channel order from the high bit is receive A, transmit A, receive B, transmit B.
- R4: When a base read ends (strobe released), only the bits it returned are cleared. An event that arrives during the read, or in its final cycle, stays set.
- R5: A one-cycle pulse on `tc_pulse[c]` or `abort_pulse[c]` sets its status bit, which holds until a base read clears it. The channel index c is 3 for receive A, 2 for transmit A, 1 for receive B and 0 for transmit B.
- R6: A base-location write also decodes `wdata[7:5]` as a command. Code 100 sets the receive A enable, 101 sets transmit B, 110 sets transmit A and 111 sets receive B. Code 001 clears all enables, and 000, 010 and 011 change nothing. A command changes only `ch_enable` and sets no status bit.
- R7: Pointer value 1 selects the interrupt control register, which reads back all 8 bits as written. Bit 7 is the master enable, bit 6 disables the lower chain, bits 5..4 are plain storage, and bits 3..0 are the channel enables, with bit c belonging to channel index c.
- R8: `irq` is 1 exactly when the master enable is 1 and some channel c has its interrupt enable set and its terminal-count or abort bit set. With the master enable at 0, `irq` stays 0.
- R9: `chain_eo` equals `chain_ei` AND NOT lower-chain-disable AND NOT `irq`.
- R10: Pointer values 2 to 31 select nothing. A read returns 0 and a write changes no register, but the access still returns the pointer to 0.
- R11: An access is counted once per strobe. A write takes effect in the first cycle of its strobe, and a read completes when its strobe is released. A cycle with both strobes low, or with chip select high, is no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Read data of the selected register |
| tc_pulse | input | 4 | Terminal-count event for each channel |
| abort_pulse | input | 4 | Abort event for each channel |
| chain_ei | input | 1 | Daisy-chain enable in |
| ch_enable | output | 4 | Channel enable levels sent to the transfer engines |
| irq | output | 1 | Interrupt request |
| chain_eo | output | 1 | Daisy-chain enable out |

## Verification
The bench targets the one-shot pointer in several ways:
- after a write that both loads the pointer and issues a command;
- after accesses to unused locations;
- under a write strobe held for several cycles.

A design that consumed the pointer twice, or never, would then write to or read from the wrong register.

The bench also places status events inside a base read and in the cycle the read is released. A naive clear-on-read would drop those events, and the check would report a lost bit.

The master-enable and lower-chain-disable gates are also exercised. A faulty gate shows up as an interrupt with the master enable clear, or as `chain_eo` active while the lower chain is disabled.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
    localparam int DW    = 8;
    localparam int PW    = 5;
    localparam int NCH   = 4;
    localparam int CMDW  = 3;
    localparam int CMD_LO = DW - CMDW;

    localparam logic [PW-1:0] A_BASE = '0;
    localparam logic [PW-1:0] A_ICR  = PW'(1);

    localparam int ICR_MIE = 7;
    localparam int ICR_DLC = 6;

    localparam int CH_TXB = 0;
    localparam int CH_RXB = 1;
    localparam int CH_TXA = 2;
    localparam int CH_RXA = 3;

    typedef enum logic [CMDW-1:0] {
        CMD_NOP    = 3'b000,
        CMD_ALLOFF = 3'b001,
        CMD_RSV2   = 3'b010,
        CMD_RSV3   = 3'b011,
        CMD_EN_RXA = 3'b100,
        CMD_EN_TXB = 3'b101,
        CMD_EN_TXA = 3'b110,
        CMD_EN_RXB = 3'b111
    } cmd_e;

    typedef struct packed {
        logic          rdq;
        logic          wrq;
        logic [PW-1:0] ptr;
    } bus_st_t;

    typedef struct packed {
        logic [DW-1:0] stat;
        logic [DW-1:0] snap;
    } stat_st_t;

    typedef struct packed {
        logic [DW-1:0]  icr;
        logic [NCH-1:0] en;
    } ctl_st_t;
endpackage

// File: rtl/sdma_busfront.sv
module sdma_busfront
    import sdma_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [PW-1:0] wptr,
    output logic [PW-1:0] ptr,
    output logic          rd_held,
    output logic          rd_start,
    output logic          rd_end,
    output logic          wr_start,
    output logic          wr_base,
    output logic          wr_icr
);
    bus_st_t st_q, st_d;
    logic rd_act, wr_act;
    logic [PW-1:0] ptr_eff;

    always_comb begin
        rd_act   = !cs_n && !rd_n && wr_n;
        wr_act   = !cs_n && !wr_n && rd_n;
        rd_start = rd_act && !st_q.rdq;
        rd_end   = st_q.rdq && !rd_act;
        wr_start = wr_act && !st_q.wrq;
        // a read that ends in this cycle is retired before a write that starts
        ptr_eff  = rd_end ? A_BASE : st_q.ptr;
        wr_base  = wr_start && (ptr_eff == A_BASE);
        wr_icr   = wr_start && (ptr_eff == A_ICR);

        st_d     = st_q;
        st_d.rdq = rd_act;
        st_d.wrq = wr_act;
        if (wr_start) begin
            st_d.ptr = (ptr_eff == A_BASE) ? wptr : A_BASE;
        end else if (rd_end) begin
            st_d.ptr = A_BASE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr     = st_q.ptr;
    assign rd_held = st_q.rdq;
endmodule

// File: rtl/sdma_status.sv
module sdma_status
    import sdma_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] tc_ev,
    input  logic [NCH-1:0] ab_ev,
    input  logic           base_rd_start,
    input  logic           base_rd_end,
    input  logic           base_rd_held,
    output logic [DW-1:0]  stat,
    output logic [DW-1:0]  view
);
    stat_st_t st_q, st_d;
    logic [DW-1:0] ev;

    always_comb begin
        ev   = {tc_ev, ab_ev};
        st_d = st_q;
        if (base_rd_start) begin
            st_d.snap = st_q.stat;
        end
        if (base_rd_end) begin
            st_d.stat = (st_q.stat & ~st_q.snap) | ev;
        end else begin
            st_d.stat = st_q.stat | ev;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign stat = st_q.stat;
    assign view = base_rd_held ? st_q.snap : st_q.stat;
endmodule

// File: rtl/sdma_ctrl.sv
module sdma_ctrl
    import sdma_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_base,
    input  logic           wr_icr,
    input  logic [DW-1:0]  wdata,
    input  logic [DW-1:0]  stat,
    input  logic           chain_ei,
    output logic [DW-1:0]  icr,
    output logic [NCH-1:0] ch_en,
    output logic           irq,
    output logic           chain_eo
);
    ctl_st_t st_q, st_d;
    logic [NCH-1:0] pend;
    cmd_e cmd;

    for (genvar c = 0; c < NCH; c++) begin : g_pend
        assign pend[c] = st_q.icr[c] && (stat[NCH + c] || stat[c]);
    end

    always_comb begin
        cmd  = cmd_e'(wdata[DW-1:CMD_LO]);
        st_d = st_q;
        if (wr_icr) begin
            st_d.icr = wdata;
        end
        if (wr_base) begin
            case (cmd)
                CMD_ALLOFF: st_d.en = '0;
                CMD_EN_RXA: st_d.en[CH_RXA] = 1'b1;
                CMD_EN_TXB: st_d.en[CH_TXB] = 1'b1;
                CMD_EN_TXA: st_d.en[CH_TXA] = 1'b1;
                CMD_EN_RXB: st_d.en[CH_RXB] = 1'b1;
                default:    st_d.en = st_q.en;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign icr      = st_q.icr;
    assign ch_en    = st_q.en;
    assign irq      = st_q.icr[ICR_MIE] && (|pend);
    assign chain_eo = chain_ei && !st_q.icr[ICR_DLC] && !irq;
endmodule

// File: rtl/sdma_regfront.sv
module sdma_regfront
    import sdma_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cs_n,
    input  logic           rd_n,
    input  logic           wr_n,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    input  logic [NCH-1:0] tc_pulse,
    input  logic [NCH-1:0] abort_pulse,
    input  logic           chain_ei,
    output logic [NCH-1:0] ch_enable,
    output logic           irq,
    output logic           chain_eo
);
    logic [PW-1:0] ptr_w;
    logic          rd_held_w, rd_start_w, rd_end_w, wr_start_w;
    logic          wr_base_w, wr_icr_w;
    logic [DW-1:0] stat_w, view_w, icr_w;
    logic          at_base;

    assign at_base = (ptr_w == A_BASE);

    sdma_busfront u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .wptr     (wdata[PW-1:0]),
        .ptr      (ptr_w),
        .rd_held  (rd_held_w),
        .rd_start (rd_start_w),
        .rd_end   (rd_end_w),
        .wr_start (wr_start_w),
        .wr_base  (wr_base_w),
        .wr_icr   (wr_icr_w)
    );

    sdma_status u_stat (
        .clk           (clk),
        .rst_n         (rst_n),
        .tc_ev         (tc_pulse),
        .ab_ev         (abort_pulse),
        .base_rd_start (rd_start_w && at_base),
        .base_rd_end   (rd_end_w && at_base),
        .base_rd_held  (rd_held_w),
        .stat          (stat_w),
        .view          (view_w)
    );

    sdma_ctrl u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_base  (wr_base_w),
        .wr_icr   (wr_icr_w),
        .wdata    (wdata),
        .stat     (stat_w),
        .chain_ei (chain_ei),
        .icr      (icr_w),
        .ch_en    (ch_enable),
        .irq      (irq),
        .chain_eo (chain_eo)
    );

    always_comb begin
        if (at_base) begin
            rdata = view_w;
        end else if (ptr_w == A_ICR) begin
            rdata = icr_w;
        end else begin
            rdata = '0;
        end
    end
endmodule

// File: rtl/sdma_regfront_chk.sv
module sdma_regfront_chk
    import sdma_pkg::*;
(
    input logic           clk,
    input logic           rst_n,
    input logic [PW-1:0]  ptr,
    input logic           rd_end,
    input logic           wr_start,
    input logic [DW-1:0]  stat,
    input logic [DW-1:0]  icr,
    input logic [NCH-1:0] tc_pulse,
    input logic [NCH-1:0] abort_pulse,
    input logic           irq,
    input logic           chain_eo
);
    p_ptr_oneshot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_end ^ wr_start) && ptr != A_BASE) |=> ptr == A_BASE);

    p_tc_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse[CH_RXA] |=> stat[DW-1]);

    p_ab_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
        abort_pulse[CH_TXB] |=> stat[0]);

    p_mie_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !icr[ICR_MIE] |-> !irq);

    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stat != '0);

    p_dlc_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        icr[ICR_DLC] |-> !chain_eo);
endmodule

bind sdma_regfront sdma_regfront_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ptr         (ptr_w),
    .rd_end      (rd_end_w),
    .wr_start    (wr_start_w),
    .stat        (stat_w),
    .icr         (icr_w),
    .tc_pulse    (tc_pulse),
    .abort_pulse (abort_pulse),
    .irq         (irq),
    .chain_eo    (chain_eo)
);

// File: tb/sim_sdma_regfront.sv
module sim_sdma_regfront;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [3:0] tc_pulse = '0, abort_pulse = '0;
    logic       chain_ei = 1'b0;
    logic [3:0] ch_enable;
    logic       irq, chain_eo;

    int tests = 0;
    int fails = 0;

    // reference model state
    int       m_ptr;
    bit [7:0] m_stat, m_snap, m_icr;
    bit [3:0] m_en;
    bit       m_rdq, m_wrq;

    always #4 clk = ~clk;

    sdma_regfront u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .wdata(wdata), .rdata(rdata), .tc_pulse(tc_pulse),
        .abort_pulse(abort_pulse), .chain_ei(chain_ei),
        .ch_enable(ch_enable), .irq(irq), .chain_eo(chain_eo)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ptr = 0; m_stat = 0; m_snap = 0; m_icr = 0; m_en = 0;
            m_rdq = 0; m_wrq = 0;
        end else begin
            bit ra, wa, rs, re, ws;
            bit [7:0] nstat;
            int p;
            ra = !cs_n && !rd_n && wr_n;
            wa = !cs_n && !wr_n && rd_n;
            rs = ra && !m_rdq;
            re = m_rdq && !ra;
            ws = wa && !m_wrq;
            nstat = m_stat | {tc_pulse, abort_pulse};
            if (re && m_ptr == 0) nstat = (m_stat & ~m_snap) | {tc_pulse, abort_pulse};
            if (rs && m_ptr == 0) m_snap = m_stat;
            p = re ? 0 : m_ptr;
            if (ws) begin
                if (p == 0) begin
                    m_ptr = int'(wdata[4:0]);
                    case (wdata[7:5])
                        3'b001: m_en = 0;
                        3'b100: m_en[3] = 1;
                        3'b101: m_en[0] = 1;
                        3'b110: m_en[2] = 1;
                        3'b111: m_en[1] = 1;
                        default: ;
                    endcase
                end else begin
                    if (p == 1) m_icr = wdata;
                    m_ptr = 0;
                end
            end else if (re) begin
                m_ptr = 0;
            end
            m_stat = nstat;
            m_rdq = ra;
            m_wrq = wa;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare();
        bit [7:0] e_rd;
        bit [3:0] pend;
        bit e_irq;
        e_rd = (m_ptr == 0) ? (m_rdq ? m_snap : m_stat) : ((m_ptr == 1) ? m_icr : 8'h00);
        pend = (m_stat[7:4] | m_stat[3:0]) & m_icr[3:0];
        e_irq = m_icr[7] && (pend != 0);
        chk("R3 model rdata", rdata, e_rd);
        chk("R6 model ch_enable", ch_enable, m_en);
        chk("R8 model irq", irq, e_irq);
        chk("R9 model chain_eo", chain_eo, chain_ei && !m_icr[6] && !e_irq);
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        compare();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(input bit [7:0] d, input int hold = 2);
        cs_n = 0; wr_n = 0; wdata = d;
        idle(hold);
        cs_n = 1; wr_n = 1;
        step();
    endtask

    task automatic rd(output bit [7:0] d);
        cs_n = 0; rd_n = 0;
        step();
        d = rdata;
        step();
        cs_n = 1; rd_n = 1;
        step();
    endtask

    task automatic pulse(input bit [3:0] tc, input bit [3:0] ab);
        tc_pulse = tc; abort_pulse = ab;
        step();
        tc_pulse = 0; abort_pulse = 0;
    endtask

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit [7:0] v;
        idle(3);
        rst_n = 1;
        step();
        // R1 reset state
        chk("R1 rdata", rdata, 0);
        chk("R1 ch_enable", ch_enable, 0);
        chk("R1 irq", irq, 0);

        // R5 / R3 / R4: latch, read, clear
        pulse(4'b1000, 4'b0000);
        idle(2);
        rd(v); chk("R3 status RxA tc", v, 8'h80);
        rd(v); chk("R4 cleared after read", v, 8'h00);
        pulse(4'b0001, 4'b0100);
        rd(v); chk("R5 TxB tc + TxA abort", v, 8'h14);

        // R2 / R7: pointer to ICR
        wr(8'h01); wr(8'h8F);
        wr(8'h01); rd(v); chk("R7 icr readback", v, 8'h8F);
        rd(v); chk("R2 pointer back at base", v, 8'h00);

        // R8 / R9: interrupt and chain
        chain_ei = 1;
        step();
        chk("R9 eo idle", chain_eo, 1);
        pulse(4'b0000, 4'b0010);
        chk("R8 irq on RxB abort", irq, 1);
        chk("R9 eo blocked by irq", chain_eo, 0);
        rd(v); chk("R3 RxB abort bit", v, 8'h02);
        chk("R8 irq drops after clear", irq, 0);
        wr(8'h01); wr(8'h0F);
        pulse(4'b0001, 4'b0000);
        chk("R8 no irq with master off", irq, 0);
        rd(v); chk("R4 clear TxB tc", v, 8'h10);
        wr(8'h01); wr(8'h4F);
        chk("R9 eo off with chain disable", chain_eo, 0);
        wr(8'h01); wr(8'h0F);
        chk("R9 eo back on", chain_eo, 1);

        // R6 commands
        wr(8'hC0); chk("R6 TxA enable", ch_enable, 4'b0100);
        wr(8'hE0); chk("R6 RxB enable", ch_enable, 4'b0110);
        wr(8'h80); chk("R6 RxA enable", ch_enable, 4'b1110);
        wr(8'hA0); chk("R6 TxB enable", ch_enable, 4'b1111);
        wr(8'h40); chk("R6 reserved no change", ch_enable, 4'b1111);
        rd(v); chk("R6 no status from command", v, 8'h00);
        wr(8'h20); chk("R6 all off", ch_enable, 4'b0000);
        wr(8'hC1); chk("R6 command with pointer load", ch_enable, 4'b0100);
        rd(v); chk("R2 same-write pointer load", v, 8'h0F);

        // R10 unused locations
        wr(8'h05); rd(v); chk("R10 unused reads zero", v, 8'h00);
        wr(8'h05); wr(8'hFF);
        chk("R10 write ignored enables", ch_enable, 4'b0100);
        wr(8'h01); rd(v); chk("R10 icr untouched", v, 8'h0F);

        // R4 events during and at end of read
        cs_n = 0; rd_n = 0; step();
        tc_pulse = 4'b0100; step(); tc_pulse = 0;
        v = rdata; chk("R4 snapshot excludes mid-read event", v, 8'h00);
        cs_n = 1; rd_n = 1; abort_pulse = 4'b1000; step(); abort_pulse = 0;
        rd(v); chk("R4 events survive clearing read", v, 8'h48);

        // R11 strobe handling
        cs_n = 0; rd_n = 0; wr_n = 0; wdata = 8'h01; idle(2);
        cs_n = 1; rd_n = 1; wr_n = 1; step();
        rd(v); chk("R11 both strobes low ignored", v, 8'h00);
        wr(8'h01, 5);
        rd(v); chk("R11 long strobe counted once", v, 8'h0F);
        cs_n = 1; wr_n = 0; wdata = 8'h01; idle(2); wr_n = 1; step();
        rd(v); chk("R11 no access without select", v, 8'h00);

        // random traffic against the model
        for (int i = 0; i < 600; i++) begin
            int k;
            k = $urandom_range(0, 5);
            cs_n = (k == 5);
            rd_n = !(k == 1 || k == 2);
            wr_n = !(k == 3);
            wdata = 8'($urandom_range(0, 255));
            if ($urandom_range(0, 3) == 0) wdata[4:2] = 0;
            tc_pulse = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
            abort_pulse = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
            chain_ei = $urandom_range(0, 1) == 1;
            step();
        end
        cs_n = 1; rd_n = 1; wr_n = 1; tc_pulse = 0; abort_pulse = 0;
        idle(2);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule